// File: doc/BRIEF.md
# Dual-Unit Dead-Time Generator for Complementary PWM Pairs

This block sits between the duty-cycle comparators of a motor-control PWM and the output drivers. It turns each raw PWM signal into a high-side and a low-side drive signal. At every transition both drives are first pulled inactive, and the drive that is turning on waits out a dead-time interval before it is asserted. This way the two switches of a half bridge never conduct together.

There are two dead-time units, A and B. Each unit has a 6-bit delay count and its own clock prescaler. For every output pair, the edge that turns the high side on and the edge that turns the low side on are each assigned to unit A or unit B, independently of each other. Both prescalers restart from zero in four cases: when the surrounding PWM reports a duty-cycle load, when either configuration word is written, and on reset. This gives the dead-time interval a defined phase relative to those events.

Top module: `dtg_top`

## Requirements
- R1: With the prescaler phase restarted in the same clock as the detected transition, the drive that is turning on is asserted exactly N×P clocks after that clock. N is the selected unit's 6-bit count and P is its prescale factor.
- R2: Unit timing word `dt_cfg_wdata`: bits [5:0] hold the unit A count and bits [7:6] hold the unit A prescale select. Bits [13:8] hold the unit B count and bits [15:14] hold the unit B prescale select. Select codes 0, 1, 2 and 3 give P = 1, 2, 4 and 8 system clocks.
- R3: Assignment word `asg_cfg_wdata`: bit 2p chooses the unit that delays pair p's low-to-high raw transition, which turns `drv_hi[p]` on. Bit 2p+1 chooses the unit that delays the high-to-low transition, which turns `drv_lo[p]` on. 0 selects unit A and 1 selects unit B.
- R4: In the clock that registers a raw transition with a nonzero selected count, both drives of the pair go inactive. Neither drive is asserted until the interval expires, and then only the drive matching the raw level is asserted.
- R5: When the selected count is zero, the drive matching the new raw level is asserted in the same clock that registers the transition, and the other drive is deasserted in that clock.
- R6: A raw transition that arrives while an interval is still running restarts the timer for the new direction, with the unit assigned to that direction. The drive that was pending is never asserted.
- R7: A pulse on `duty_load` returns both prescalers to phase zero.
- R8: A write strobe on either configuration word returns both prescalers to phase zero.
- R9: `drv_hi[p]` and `drv_lo[p]` are never both 1.
- R10: While `rst` is high, all drives are 0. All configuration fields reset to zero. With raw inputs low, every `drv_lo` is 1 after the first clock edge following reset release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pwm_raw | input | NUM_PAIRS | Raw PWM level per pair |
| dt_cfg_we | input | 1 | Write strobe for the unit timing word |
| dt_cfg_wdata | input | 16 | Unit timing word (counts and prescale selects) |
| asg_cfg_we | input | 1 | Write strobe for the edge-assignment word |
| asg_cfg_wdata | input | 2*NUM_PAIRS | Per-pair unit choice for each edge direction |
| duty_load | input | 1 | Duty-cycle load event, restarts prescalers |
| drv_hi | output | NUM_PAIRS | High-side drive per pair |
| drv_lo | output | NUM_PAIRS | Low-side drive per pair |

## Verification
The vector table covers rising and falling transitions on different pairs, and each of them measures the delay in clocks. Unit A and unit B carry different counts and prescale factors, so a wrong unit choice, a wrong prescale code or a swapped direction bit each produces a distinct wrong delay. A zero count on one unit separates the pass-through path from the timed path. The maximum count at the largest prescale shows whether the full counter width and the largest factor are used. Directed cases then check four things: the reset state, a retoggle inside the interval (the pending drive must stay off and the timer must restart), alignment by a configuration write instead of a duty load, and that the two drives of a pair never overlap in any window.

// File: rtl/dtg_pkg.sv
package dtg_pkg;

    localparam int DT_CNT_W  = 6;
    localparam int DT_PS_W   = 2;
    localparam int PC_W      = (1 << DT_PS_W) - 1;
    localparam int UNIT_W    = DT_CNT_W + DT_PS_W;
    localparam int NUM_UNITS = 2;

    typedef enum logic {
        UNIT_A = 1'b0,
        UNIT_B = 1'b1
    } dt_unit_e;

    typedef enum logic {
        PS_IDLE = 1'b0,
        PS_WAIT = 1'b1
    } pair_state_e;

    typedef struct packed {
        logic [DT_PS_W-1:0]  ps;
        logic [DT_CNT_W-1:0] cnt;
    } dt_unit_cfg_t;

    typedef struct packed {
        dt_unit_e fall_sel;
        dt_unit_e rise_sel;
    } pair_asg_t;

    typedef struct packed {
        logic hi;
        logic lo;
    } drive_t;

    function automatic logic [PC_W-1:0] ps_limit(input logic [DT_PS_W-1:0] ps);
        logic [PC_W-1:0] m;
        m = '0;
        for (int i = 0; i < PC_W; i++) begin
            if (i < int'(ps)) m[i] = 1'b1;
        end
        return m;
    endfunction

    function automatic drive_t level_drive(input logic lvl);
        drive_t d;
        d.hi = lvl;
        d.lo = ~lvl;
        return d;
    endfunction

endpackage

// File: rtl/dtg_prescaler.sv
module dtg_prescaler
    import dtg_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                clr,
    input  logic [DT_PS_W-1:0]  ps,
    output logic                tick,
    output logic [PC_W-1:0]     phase
);
    logic [PC_W-1:0] limit;

    assign limit = ps_limit(ps);
    assign tick  = !clr && (phase >= limit);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            phase <= '0;
        end else if (phase >= limit) begin
            phase <= '0;
        end else begin
            phase <= phase + PC_W'(1);
        end
    end
endmodule

// File: rtl/dtg_cfg_regs.sv
module dtg_cfg_regs
    import dtg_pkg::*;
#(
    parameter int NUM_PAIRS = 3
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     dt_we,
    input  logic [2*UNIT_W-1:0]      dt_wdata,
    input  logic                     asg_we,
    input  logic [2*NUM_PAIRS-1:0]   asg_wdata,
    output dt_unit_cfg_t             ucfg [NUM_UNITS],
    output pair_asg_t                asg  [NUM_PAIRS],
    output logic                     any_write
);
    logic [2*UNIT_W-1:0]    dt_q;
    logic [2*NUM_PAIRS-1:0] asg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            dt_q  <= '0;
            asg_q <= '0;
        end else begin
            if (dt_we)  dt_q  <= dt_wdata;
            if (asg_we) asg_q <= asg_wdata;
        end
    end

    assign any_write = dt_we || asg_we;

    for (genvar u = 0; u < NUM_UNITS; u++) begin : g_ucfg
        assign ucfg[u] = dt_unit_cfg_t'(dt_q[u*UNIT_W +: UNIT_W]);
    end

    for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_asg
        assign asg[p] = pair_asg_t'(asg_q[2*p +: 2]);
    end
endmodule

// File: rtl/dtg_pair.sv
module dtg_pair
    import dtg_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          pwm_in,
    input  logic          tick_a,
    input  logic          tick_b,
    input  dt_unit_cfg_t  cfg_a,
    input  dt_unit_cfg_t  cfg_b,
    input  pair_asg_t     asg,
    output drive_t        drv
);
    logic                pwm_q;
    pair_state_e         state;
    logic [DT_CNT_W-1:0] timer;
    dt_unit_e            unit_q;

    logic                edge_seen;
    dt_unit_e            new_unit;
    logic [DT_CNT_W-1:0] new_cnt;
    logic                run_tick;
    logic                expire;

    assign edge_seen = (pwm_in != pwm_q);
    assign new_unit  = pwm_in ? asg.rise_sel : asg.fall_sel;
    assign new_cnt   = (new_unit == UNIT_B) ? cfg_b.cnt : cfg_a.cnt;
    assign run_tick  = (unit_q == UNIT_B) ? tick_b : tick_a;
    assign expire    = (timer == '0) || (run_tick && (timer == DT_CNT_W'(1)));

    always_ff @(posedge clk) begin
        if (rst) begin
            pwm_q  <= 1'b0;
            state  <= PS_WAIT;
            timer  <= '0;
            unit_q <= UNIT_A;
            drv    <= '0;
        end else begin
            pwm_q <= pwm_in;
            if (edge_seen) begin
                unit_q <= new_unit;
                timer  <= new_cnt;
                if (new_cnt == '0) begin
                    drv   <= level_drive(pwm_in);
                    state <= PS_IDLE;
                end else begin
                    drv   <= '0;
                    state <= PS_WAIT;
                end
            end else if (state == PS_WAIT) begin
                if (expire) begin
                    drv   <= level_drive(pwm_q);
                    state <= PS_IDLE;
                end else if (run_tick) begin
                    timer <= timer - DT_CNT_W'(1);
                end
            end
        end
    end
endmodule

// File: rtl/dtg_top.sv
module dtg_top
    import dtg_pkg::*;
#(
    parameter int NUM_PAIRS = 3
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [NUM_PAIRS-1:0]   pwm_raw,
    input  logic                   dt_cfg_we,
    input  logic [2*UNIT_W-1:0]    dt_cfg_wdata,
    input  logic                   asg_cfg_we,
    input  logic [2*NUM_PAIRS-1:0] asg_cfg_wdata,
    input  logic                   duty_load,
    output logic [NUM_PAIRS-1:0]   drv_hi,
    output logic [NUM_PAIRS-1:0]   drv_lo
);
    dt_unit_cfg_t ucfg [NUM_UNITS];
    pair_asg_t    asg  [NUM_PAIRS];
    logic         any_write;
    logic         presc_clr;
    logic         tick  [NUM_UNITS];
    logic [PC_W-1:0] phase [NUM_UNITS];

    dtg_cfg_regs #(.NUM_PAIRS(NUM_PAIRS)) u_cfg (
        .clk       (clk),
        .rst       (rst),
        .dt_we     (dt_cfg_we),
        .dt_wdata  (dt_cfg_wdata),
        .asg_we    (asg_cfg_we),
        .asg_wdata (asg_cfg_wdata),
        .ucfg      (ucfg),
        .asg       (asg),
        .any_write (any_write)
    );

    assign presc_clr = duty_load || any_write;

    for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
        dtg_prescaler u_ps (
            .clk   (clk),
            .rst   (rst),
            .clr   (presc_clr),
            .ps    (ucfg[u].ps),
            .tick  (tick[u]),
            .phase (phase[u])
        );
    end

    for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
        drive_t d;
        dtg_pair u_pair (
            .clk    (clk),
            .rst    (rst),
            .pwm_in (pwm_raw[p]),
            .tick_a (tick[0]),
            .tick_b (tick[1]),
            .cfg_a  (ucfg[0]),
            .cfg_b  (ucfg[1]),
            .asg    (asg[p]),
            .drv    (d)
        );
        assign drv_hi[p] = d.hi;
        assign drv_lo[p] = d.lo;
    end

    logic [PC_W-1:0]     phase_a, phase_b;
    logic [DT_CNT_W-1:0] cnt_a, cnt_b;
    logic [2*NUM_PAIRS-1:0] asg_bits;

    assign phase_a = phase[0];
    assign phase_b = phase[1];
    assign cnt_a   = ucfg[0].cnt;
    assign cnt_b   = ucfg[1].cnt;
    for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_asg_bits
        assign asg_bits[2*p +: 2] = asg[p];
    end
endmodule

// File: rtl/dtg_chk.sv
module dtg_chk
    import dtg_pkg::*;
#(
    parameter int NUM_PAIRS = 3
) (
    input logic                   clk,
    input logic                   rst,
    input logic [NUM_PAIRS-1:0]   pwm_raw,
    input logic [NUM_PAIRS-1:0]   drv_hi,
    input logic [NUM_PAIRS-1:0]   drv_lo,
    input logic                   duty_load,
    input logic                   dt_cfg_we,
    input logic                   asg_cfg_we,
    input logic [PC_W-1:0]        phase_a,
    input logic [PC_W-1:0]        phase_b,
    input logic [DT_CNT_W-1:0]    cnt_a,
    input logic [DT_CNT_W-1:0]    cnt_b,
    input logic [2*NUM_PAIRS-1:0] asg_bits
);
    p_presc_clr_duty_r7: assert property (@(posedge clk) disable iff (rst)
        duty_load |=> (phase_a == '0 && phase_b == '0));

    p_presc_clr_write_r8: assert property (@(posedge clk) disable iff (rst)
        (dt_cfg_we || asg_cfg_we) |=> (phase_a == '0 && phase_b == '0));

    for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_p
        logic [DT_CNT_W-1:0] rise_cnt, fall_cnt;
        assign rise_cnt = asg_bits[2*p]   ? cnt_b : cnt_a;
        assign fall_cnt = asg_bits[2*p+1] ? cnt_b : cnt_a;

        p_no_overlap_r9: assert property (@(posedge clk) disable iff (rst)
            !(drv_hi[p] && drv_lo[p]));

        p_rise_blank_r4: assert property (@(posedge clk) disable iff (rst)
            (!$past(rst) && pwm_raw[p] && !$past(pwm_raw[p]) && rise_cnt != '0)
            |=> (!drv_hi[p] && !drv_lo[p]));

        p_fall_blank_r4: assert property (@(posedge clk) disable iff (rst)
            (!$past(rst) && !pwm_raw[p] && $past(pwm_raw[p]) && fall_cnt != '0)
            |=> (!drv_hi[p] && !drv_lo[p]));

        p_rise_zero_r5: assert property (@(posedge clk) disable iff (rst)
            (!$past(rst) && pwm_raw[p] && !$past(pwm_raw[p]) && rise_cnt == '0)
            |=> (drv_hi[p] && !drv_lo[p]));

        p_hi_level_r4: assert property (@(posedge clk) disable iff (rst)
            $rose(drv_hi[p]) |-> $past(pwm_raw[p]));

        p_lo_level_r4: assert property (@(posedge clk) disable iff (rst)
            $rose(drv_lo[p]) |-> !$past(pwm_raw[p]));
    end
endmodule

bind dtg_top dtg_chk #(.NUM_PAIRS(NUM_PAIRS)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .pwm_raw    (pwm_raw),
    .drv_hi     (drv_hi),
    .drv_lo     (drv_lo),
    .duty_load  (duty_load),
    .dt_cfg_we  (dt_cfg_we),
    .asg_cfg_we (asg_cfg_we),
    .phase_a    (phase_a),
    .phase_b    (phase_b),
    .cnt_a      (cnt_a),
    .cnt_b      (cnt_b),
    .asg_bits   (asg_bits)
);

// File: tb/sim_dtg_top.sv
module sim_dtg_top;
    localparam int CLK_PERIOD = 10;
    localparam int NP         = 3;
    localparam int NV         = 9;
    localparam int SETTLE     = 520;

    // unit word {psB,cntB,psA,cntA}; assignment bits 2p rise, 2p+1 fall
    localparam logic [15:0] V_DT  [NV] = '{16'h0005, 16'h0085, 16'hC743, 16'hC743,
                                           16'hC743, 16'h0009, 16'h0009, 16'h00FF, 16'h01FF};
    localparam logic [5:0]  V_ASG [NV] = '{6'b000000, 6'b000000, 6'b000100, 6'b000100,
                                           6'b001000, 6'b010000, 6'b010000, 6'b000000, 6'b000010};
    localparam int          V_PAIR[NV] = '{0, 0, 1, 1, 1, 2, 2, 0, 0};
    localparam logic        V_DIR [NV] = '{1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0};
    localparam int          V_EXP [NV] = '{5, 20, 56, 6, 56, 0, 9, 504, 1};

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NP-1:0] pwm_raw = '0;
    logic          dt_cfg_we = 1'b0;
    logic [15:0]   dt_cfg_wdata = '0;
    logic          asg_cfg_we = 1'b0;
    logic [5:0]    asg_cfg_wdata = '0;
    logic          duty_load = 1'b0;
    logic [NP-1:0] drv_hi, drv_lo;

    int   n_checks = 0;
    int   n_fail   = 0;
    logic done     = 1'b0;
    logic [5:0] cur_asg = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dtg_top #(.NUM_PAIRS(NP)) u0 (
        .clk(clk), .rst(rst), .pwm_raw(pwm_raw),
        .dt_cfg_we(dt_cfg_we), .dt_cfg_wdata(dt_cfg_wdata),
        .asg_cfg_we(asg_cfg_we), .asg_cfg_wdata(asg_cfg_wdata),
        .duty_load(duty_load), .drv_hi(drv_hi), .drv_lo(drv_lo)
    );

    task automatic check(input logic ok, input string what, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", what, act, exp);
        end
    endtask

    task automatic write_dt(input logic [15:0] w);
        @(negedge clk); dt_cfg_we = 1'b1; dt_cfg_wdata = w;
        @(negedge clk); dt_cfg_we = 1'b0;
    endtask

    task automatic write_asg(input logic [5:0] w);
        @(negedge clk); asg_cfg_we = 1'b1; asg_cfg_wdata = w; cur_asg = w;
        @(negedge clk); asg_cfg_we = 1'b0;
    endtask

    task automatic wait_cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    // drive one transition and count clocks until the target drive turns on
    task automatic do_edge(input int p, input logic dir, input logic via_write,
                           output int m, output logic both_on, output logic other_on);
        @(negedge clk);
        pwm_raw[p] = dir;
        if (via_write) begin
            asg_cfg_we = 1'b1; asg_cfg_wdata = cur_asg;
        end else begin
            duty_load = 1'b1;
        end
        @(posedge clk); @(negedge clk);
        duty_load = 1'b0; asg_cfg_we = 1'b0;
        m = 0; both_on = 1'b0; other_on = 1'b0;
        while (m < 700) begin
            if (drv_hi[p] && drv_lo[p]) both_on = 1'b1;
            if (dir ? drv_hi[p] : drv_lo[p]) break;
            if (dir ? drv_lo[p] : drv_hi[p]) other_on = 1'b1;
            @(posedge clk); @(negedge clk);
            m++;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        int m;
        logic both, other;

        // R10 reset state
        repeat (3) @(negedge clk);
        check(drv_hi == '0 && drv_lo == '0, "R10 drives low in reset", {drv_hi, drv_lo}, 0);
        rst = 1'b0;
        @(negedge clk);
        check(drv_lo == '1 && drv_hi == '0, "R10 lo on after release", {drv_hi, drv_lo}, 7);

        // vector table: R1 R2 R3 R5 R7 R4 R9
        for (int v = 0; v < NV; v++) begin
            write_dt(V_DT[v]);
            write_asg(V_ASG[v]);
            @(negedge clk); pwm_raw[V_PAIR[v]] = ~V_DIR[v];
            wait_cycles(SETTLE);
            do_edge(V_PAIR[v], V_DIR[v], 1'b0, m, both, other);
            check(m == V_EXP[v], $sformatf("R1 R2 R3 R5 R7 delay vec %0d", v), m, V_EXP[v]);
            check(!other, $sformatf("R4 other drive off vec %0d", v), other, 0);
            check(!both, $sformatf("R9 no overlap vec %0d", v), both, 0);
        end

        // R6 retoggle inside interval
        write_dt(16'h000A);
        write_asg(6'b000000);
        @(negedge clk); pwm_raw[0] = 1'b0;
        wait_cycles(SETTLE);
        @(negedge clk); pwm_raw[0] = 1'b1; duty_load = 1'b1;
        @(negedge clk); duty_load = 1'b0;
        begin
            logic seen_hi;
            seen_hi = 1'b0;
            for (int i = 0; i < 4; i++) begin
                if (drv_hi[0] || drv_lo[0]) seen_hi = 1'b1;
                @(negedge clk);
            end
            check(!seen_hi, "R6 both off before retoggle", seen_hi, 0);
        end
        do_edge(0, 1'b0, 1'b0, m, both, other);
        check(m == 10, "R6 timer restarts on retoggle", m, 10);
        check(!other, "R6 pending hi never asserted", other, 0);
        wait_cycles(20);
        check(drv_hi[0] == 1'b0 && drv_lo[0] == 1'b1, "R6 settled low side", {drv_hi[0], drv_lo[0]}, 1);

        // R8 alignment through a configuration write
        write_dt(16'h00C2);
        @(negedge clk); pwm_raw[0] = 1'b0;
        wait_cycles(SETTLE);
        do_edge(0, 1'b1, 1'b1, m, both, other);
        check(m == 16, "R8 cfg write clears prescaler", m, 16);
        check(!both, "R9 no overlap cfg-write case", both, 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule